// File: doc/BRIEF.md
# Peripheral Interrupt Priority Arbiter

This block holds one 16-bit priority register and arbitrates among five on-chip interrupt sources: a divider unit, DMA channels 0 and 1, a watchdog timer and a bus state controller. Software sets a 4-bit level for each of three source groups through a small register bus. The divider has its own level. The two DMA channels share one level. The watchdog and the bus controller share the third.

The request inputs are level sensitive. Each cycle the arbiter takes the pending source with the highest level and presents its identifier and level with a valid flag. These outputs go to the CPU's mask comparison. A level of zero masks a source. Fixed orders settle ties inside a shared group and between groups. When the standby input is high the register holds its contents and ignores writes. Arbitration continues from the stored levels.

Top module: `irq_prio_arb`

## Requirements
- R1: The register sits at bus address 0. A write with `bus_we` high at address 0 stores `bus_wdata[15:4]` on the clock edge. `bus_rdata` shows the register combinationally at address 0. Any other address reads 0x0000, and a write to it changes nothing.
- R2: Bits 3:0 of the register are reserved. They always read 0, and the values written to them are discarded.
- R3: Reset (`rst_n` low) clears the register to 0x0000 and drives `win_valid`, `win_id` and `win_level` to 0.
- R4: While `standby` is high, writes are ignored and the register keeps its value. Arbitration still runs on the stored levels.
- R5: The divider level is in bits 15:12, the DMA level in bits 11:8 and the watchdog/bus-controller level in bits 7:4. Among the pending sources, the one with the numerically greatest level wins.
- R6: When both DMA channels request, channel 0 (id 1) wins over channel 1 (id 2).
- R7: When both the watchdog and the bus controller request, the watchdog (id 3) wins over the bus controller (id 4).
- R8: A source whose group level is 0 never wins. If no pending source has a nonzero level, `win_valid` is 0, `win_id` is 0 and `win_level` is 0.
- R9: When groups tie at an equal nonzero level, the winner follows the order divider (id 0), DMA 0 (id 1), DMA 1 (id 2), watchdog (id 3), bus controller (id 4).
- R10: The outputs are registered. They show the arbitration result for the requests and register contents present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Standby: hold the register and block writes |
| bus_addr | input | 4 | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 16 | Register bus write data |
| bus_rdata | output | 16 | Register bus read data (combinational) |
| req_div | input | 1 | Divider unit request |
| req_dma0 | input | 1 | DMA channel 0 request |
| req_dma1 | input | 1 | DMA channel 1 request |
| req_wdt | input | 1 | Watchdog timer request |
| req_bsc | input | 1 | Bus state controller request |
| win_valid | output | 1 | A pending source with a nonzero level exists |
| win_id | output | 3 | Winning source: 0 div, 1 DMA0, 2 DMA1, 3 WDT, 4 BSC |
| win_level | output | 4 | Level of the winning source |

## Verification
A register write and a change of the requests can land on the same clock edge. In that case the next result must come from the new level and the new request pattern together. The bench provokes this in its random phase: every iteration writes a random priority word, sometimes under standby, while it drives a random request vector. A bench function then recomputes the winner from the modelled register contents and compares it with the outputs one edge later. Directed cases cover tie-breaks inside each group, ties between groups, masking at level zero, the reserved bits and the one-cycle latency.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int NSRC   = 5;
   localparam int NFIELD = 3;

   typedef enum logic [2:0] {
      SRC_DIV  = 3'd0,
      SRC_DMA0 = 3'd1,
      SRC_DMA1 = 3'd2,
      SRC_WDT  = 3'd3,
      SRC_BSC  = 3'd4
   } src_e;

   // Field index for each source; field 0 is the most significant nibble group.
   function automatic int field_of(input int src);
      case (src)
         0:       return 0;
         1, 2:    return 1;
         default: return 2;
      endcase
   endfunction
endpackage

// File: rtl/irq_prio_regfile.sv
module irq_prio_regfile #(
   parameter int DATA_W   = 16,
   parameter int LVL_W    = 4,
   parameter int NFIELD   = 3,
   parameter int ADDR_W   = 4,
   parameter int REG_ADDR = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          standby,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_we,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   output logic [DATA_W-1:0]             prio_q,
   output logic [NFIELD-1:0][LVL_W-1:0]  field_lvl
);
   localparam int RES_W = DATA_W - NFIELD * LVL_W;
   localparam logic [DATA_W-1:0] WMASK = {DATA_W{1'b1}} << RES_W;
   localparam logic [ADDR_W-1:0] SEL   = ADDR_W'(REG_ADDR);

   initial begin
      if (RES_W < 0) $error("irq_prio_regfile: fields do not fit in DATA_W");
      if (REG_ADDR >= (1 << ADDR_W)) $error("irq_prio_regfile: REG_ADDR out of range");
   end

   logic hit;
   assign hit = (bus_addr == SEL);

   always_ff @(posedge clk) begin
      if (!rst_n)
         prio_q <= '0;
      else if (hit && bus_we && !standby)
         prio_q <= bus_wdata & WMASK;
   end

   assign bus_rdata = hit ? (prio_q & WMASK) : '0;

   for (genvar f = 0; f < NFIELD; f++) begin : g_field
      assign field_lvl[f] = prio_q[DATA_W-1-f*LVL_W -: LVL_W];
   end
endmodule

// File: rtl/irq_prio_lvlmap.sv
module irq_prio_lvlmap #(
   parameter int LVL_W  = 4,
   parameter int NFIELD = 3,
   parameter int NSRC   = 5
) (
   input  logic [NFIELD-1:0][LVL_W-1:0] field_lvl,
   input  logic [NSRC-1:0]              req,
   output logic [NSRC-1:0][LVL_W-1:0]   cand_lvl
);
   initial begin
      if (NSRC != irq_prio_pkg::NSRC) $error("irq_prio_lvlmap: NSRC mismatch");
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam int F = irq_prio_pkg::field_of(s);
      assign cand_lvl[s] = req[s] ? field_lvl[F] : '0;
   end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
   parameter int LVL_W = 4,
   parameter int NSRC  = 5,
   parameter int IDX_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0][LVL_W-1:0] cand_lvl,
   output logic                       any,
   output logic [IDX_W-1:0]           best_idx,
   output logic [LVL_W-1:0]           best_lvl
);
   initial begin
      if (NSRC < 2) $error("irq_prio_select: need at least two sources");
   end

   // Strictly greater replaces, so the lowest index wins any tie.
   always_comb begin
      best_idx = '0;
      best_lvl = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (cand_lvl[s] > best_lvl) begin
            best_lvl = cand_lvl[s];
            best_idx = IDX_W'(s);
         end
      end
   end

   assign any = (best_lvl != '0);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int DATA_W   = 16,
   parameter int LVL_W    = 4,
   parameter int ADDR_W   = 4,
   parameter int REG_ADDR = 0,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              req_div,
   input  logic              req_dma0,
   input  logic              req_dma1,
   input  logic              req_wdt,
   input  logic              req_bsc,
   output logic              win_valid,
   output logic [2:0]        win_id,
   output logic [LVL_W-1:0]  win_level
);
   localparam int NSRC   = irq_prio_pkg::NSRC;
   localparam int NFIELD = irq_prio_pkg::NFIELD;
   localparam int IDX_W  = $clog2(NSRC);

   initial begin
      if (IDX_W > 3) $error("irq_prio_arb: id output too narrow");
      if (LVL_W < 1) $error("irq_prio_arb: LVL_W must be positive");
   end

   logic [DATA_W-1:0]            prio_q;
   logic [NFIELD-1:0][LVL_W-1:0] field_lvl;
   logic [NSRC-1:0][LVL_W-1:0]   cand_lvl;
   logic [NSRC-1:0]              req_vec;
   logic                         any;
   logic [IDX_W-1:0]             best_idx;
   logic [LVL_W-1:0]             best_lvl;
   logic [2:0]                   id_d;

   assign req_vec = {req_bsc, req_wdt, req_dma1, req_dma0, req_div};

   irq_prio_regfile #(
      .DATA_W(DATA_W), .LVL_W(LVL_W), .NFIELD(NFIELD),
      .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .standby(standby),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .prio_q(prio_q), .field_lvl(field_lvl)
   );

   irq_prio_lvlmap #(.LVL_W(LVL_W), .NFIELD(NFIELD), .NSRC(NSRC)) u_map (
      .field_lvl(field_lvl), .req(req_vec), .cand_lvl(cand_lvl)
   );

   irq_prio_select #(.LVL_W(LVL_W), .NSRC(NSRC), .IDX_W(IDX_W)) u_sel (
      .cand_lvl(cand_lvl), .any(any), .best_idx(best_idx), .best_lvl(best_lvl)
   );

   assign id_d = any ? 3'(best_idx) : 3'd0;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win_valid <= 1'b0;
            win_id    <= 3'd0;
            win_level <= '0;
         end else begin
            win_valid <= any;
            win_id    <= id_d;
            win_level <= best_lvl;
         end
      end
   end else begin : g_out_comb
      assign win_valid = any;
      assign win_id    = id_d;
      assign win_level = best_lvl;
   end
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk #(
   parameter int DATA_W  = 16,
   parameter int LVL_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              standby,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] prio_q,
   input logic              req_div,
   input logic              req_dma0,
   input logic              req_dma1,
   input logic              req_wdt,
   input logic              req_bsc,
   input logic              win_valid,
   input logic [2:0]        win_id,
   input logic [LVL_W-1:0]  win_level
);
   // R2
   always_comb begin
      reserved_zero_chk: assert (bus_rdata[3:0] == 4'd0);
   end

   // R4
   standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> $stable(prio_q));

   // R8
   valid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_level != '0));

   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid |-> (win_id == 3'd0 && win_level == '0));

   if (OUT_REG) begin : g_seq
      // R6
      dma_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && win_id == 3'd2) |-> !$past(req_dma0));

      // R7
      wdt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && win_id == 3'd4) |-> !$past(req_wdt));

      // R10
      needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         win_valid |-> $past(req_div | req_dma0 | req_dma1 | req_wdt | req_bsc));
   end
endmodule

bind irq_prio_arb irq_prio_arb_chk #(
   .DATA_W(DATA_W), .LVL_W(LVL_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .standby(standby), .bus_rdata(bus_rdata),
   .prio_q(prio_q), .req_div(req_div), .req_dma0(req_dma0),
   .req_dma1(req_dma1), .req_wdt(req_wdt), .req_bsc(req_bsc),
   .win_valid(win_valid), .win_id(win_id), .win_level(win_level)
);

// File: tb/irq_prio_arb_test.sv
module irq_prio_arb_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [4:0]  req = '0;
   logic        win_valid;
   logic [2:0]  win_id;
   logic [3:0]  win_level;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] model = '0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_prio_arb uut (
      .clk(clk), .rst_n(rst_n), .standby(standby),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .req_div(req[0]), .req_dma0(req[1]), .req_dma1(req[2]),
      .req_wdt(req[3]), .req_bsc(req[4]),
      .win_valid(win_valid), .win_id(win_id), .win_level(win_level)
   );

   // {valid, id[2:0], level[3:0]}
   function automatic logic [7:0] ref_arb(input logic [15:0] r, input logic [4:0] q);
      logic [3:0] l [5];
      logic [3:0] best;
      logic [2:0] id;
      l[0] = r[15:12]; l[1] = r[11:8]; l[2] = r[11:8]; l[3] = r[7:4]; l[4] = r[7:4];
      best = '0; id = '0;
      for (int s = 0; s < 5; s++)
         if (q[s] && l[s] > best) begin best = l[s]; id = 3'(s); end
      return {(best != 0), id, best};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_out(input string tag);
      check(tag, {24'd0, win_valid, win_id, win_level}, {24'd0, ref_arb(model, req)});
   endtask

   // Drive a bus write at a negedge; register updates on the next posedge.
   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk);
      if (a == 4'd0 && !standby) model = d & 16'hFFF0;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 4'd0;
   endtask

   // Settle: one further edge so the outputs reflect register and requests.
   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R3 reset state
      check("R3 outputs in reset", {29'd0, win_valid, win_id} , 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 register after reset", {16'd0, bus_rdata}, 32'd0);
      check("R3 level after reset", {28'd0, win_level}, 32'd0);

      // R1 R2 readback with reserved bits dropped
      wr(4'd0, 16'hFFFF);
      check("R1 R2 readback", {16'd0, bus_rdata}, 32'h0000FFF0);
      wr(4'd0, 16'hA5C3);
      check("R2 reserved discarded", {16'd0, bus_rdata}, 32'h0000A5C0);
      // R1 other address
      wr(4'd1, 16'h1230);
      bus_addr = 4'd1; #0;
      @(negedge clk);
      check("R1 other address reads zero", {16'd0, bus_rdata}, 32'd0);
      bus_addr = 4'd0;
      @(negedge clk);
      check("R1 other address write ignored", {16'd0, bus_rdata}, 32'h0000A5C0);

      // R4 standby
      standby = 1'b1;
      wr(4'd0, 16'h1110);
      check("R4 write blocked in standby", {16'd0, bus_rdata}, 32'h0000A5C0);
      req = 5'b00001; settle();
      check_out("R4 arbitration runs in standby");
      standby = 1'b0;

      // R6 DMA channel order
      wr(4'd0, 16'h3730);
      req = 5'b00110; settle();
      check_out("R6 dma0 over dma1");
      check("R6 id", {29'd0, win_id}, 32'd1);
      // R5 divider lower than DMA
      req = 5'b00111; settle();
      check("R5 highest level wins", {29'd0, win_id}, 32'd1);
      // R7 WDT over BSC
      wr(4'd0, 16'h0090);
      req = 5'b11000; settle();
      check("R7 wdt over bsc", {29'd0, win_id}, 32'd3);
      req = 5'b10000; settle();
      check_out("R7 bsc alone");
      // R8 masked level
      wr(4'd0, 16'h0500);
      req = 5'b11001; settle();
      check("R8 masked gives no valid", {28'd0, win_valid, win_id}, 32'd0);
      check("R8 masked level zero", {28'd0, win_level}, 32'd0);
      // R9 cross-group ties
      wr(4'd0, 16'h6660);
      req = 5'b11111; settle();
      check("R9 divider first", {29'd0, win_id}, 32'd0);
      req = 5'b11100; settle();
      check("R9 dma1 before wdt", {29'd0, win_id}, 32'd2);
      req = 5'b11000; settle();
      check("R9 wdt before bsc", {29'd0, win_id}, 32'd3);

      // R10 one-cycle latency
      wr(4'd0, 16'h4820);
      req = 5'b00000; settle();
      req = 5'b00010;
      check("R10 no change before edge", {31'd0, win_valid}, 32'd0);
      @(posedge clk); #1;
      check("R10 valid after one edge", {28'd0, win_level}, 32'd8);

      // Random mix: write and request change on the same edge (R5, R9)
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         standby = ($urandom % 8) == 0;
         req = 5'($urandom);
         wr(4'd0, 16'($urandom));
         settle();
         check_out("R5 R9 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule